// File: doc/BRIEF.md
# Dual-Address DMA Transfer Engine

This block copies data from a source address to a destination address for the chip, so that a processor does not have to move each item itself. Each transfer reads one unit of 8, 16 or 32 bits, holds it inside the engine, and then writes it out. The block is the only master on a simple synchronous memory bus. Every access on that bus raises a request and then waits for ready. A 24-bit count sets how many transfers a job contains.

The source register can be used in two ways. In direct mode it gives the data address. In indirect mode it points to a table entry, and the 32-bit data address is first fetched from that entry. An optional reload mode returns the source register to its programmed start after every fourth completed transfer, so the same four items can be sent again and again.

A job is programmed through a single load strobe together with its configuration inputs. The load is accepted only while the engine is inactive. Once loaded, transfers start in one of two ways: they run back to back under an internal auto-request, or one starts each time the engine is idle and a peripheral request line is high. When the count is used up, the engine drops its active flag, sets a sticky done flag and, if enabled, raises an interrupt.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_req, act, done and irq are all low.
- R2: A direct transfer is one read at the source address followed by one write at the destination address. bus_size encodes the unit as 0 = 8 bit, 1 = 16 bit and 2 = 32 bit. The written data is the low unit bits of the read data, with the upper bits zero. Data sits in the low bits, little-endian.
- R3: While bus_req is high and bus_ready is low, bus_req, bus_addr, bus_we, bus_size and bus_wdata keep their values into the next cycle.
- R4: After each transfer, the source address and the destination address each either stay fixed or advance by the unit size (1, 2 or 4 bytes). Each has its own control input.
- R5: An indirect transfer makes four accesses in this order:
  - a 16-bit read at the pointer;
  - a 16-bit read at pointer+2, giving the upper half of the 32-bit data address;
  - a data read at that address;
  - the write.
  With source increment on, the pointer advances by 4.
- R6: With reload on, the source register returns to its loaded value after every fourth completed transfer.
- R7: With auto-request on, transfers run back to back with exactly one bus-idle cycle between them. Without it, a transfer starts from idle only when periph_req is high.
- R8: After the programmed number of transfers, act falls and done rises. irq equals done AND the interrupt enable. A count of 0 means 16,777,216 transfers.
- R9: While act is low, bus_req stays low and periph_req has no effect.
- R10: cfg_load while act is high is ignored. When act is low, cfg_load takes the new configuration, clears done and raises act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for a new job |
| cfg_src | input | 32 | Source address or pointer-table address |
| cfg_dst | input | 32 | Destination address |
| cfg_count | input | 24 | Number of transfers (0 = 2^24) |
| cfg_unit | input | 2 | Unit size code |
| cfg_src_inc | input | 1 | Source advances after each transfer |
| cfg_dst_inc | input | 1 | Destination advances after each transfer |
| cfg_indirect | input | 1 | Source register is a pointer |
| cfg_reload | input | 1 | Source reload every fourth transfer |
| cfg_auto | input | 1 | Internal auto-request |
| cfg_irq_en | input | 1 | Interrupt enable |
| periph_req | input | 1 | Peripheral transfer request (level) |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ready |
| bus_ready | input | 1 | Access completes this cycle |
| act | output | 1 | Job in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
On every cycle the assertions check four things:
- the bus outputs stay stable while a request is stalled;
- bus_req stays low while the engine is inactive;
- the single idle cycle follows each accepted write;
- the interrupt is tied to done, and done rises only as act falls.

Only the bench's scenarios can show that the copied memory contents are correct. The same holds for the access order of indirect fetches, the address stepping and reload pattern, the gating by the peripheral request, and that a load issued mid-job is ignored. The bench checks these against its own reference copy of memory.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 24;
    localparam int PTR_STEP = 4;

    typedef enum logic [1:0] {
        UNIT_B = 2'd0,
        UNIT_H = 2'd1,
        UNIT_W = 2'd2,
        UNIT_X = 2'd3
    } unit_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PLO,
        PH_PHI,
        PH_RD,
        PH_WR
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  count;
        unit_e             unit;
        logic              src_inc;
        logic              dst_inc;
        logic              indirect;
        logic              reload;
        logic              auto_req;
        logic              irq_en;
    } job_cfg_t;

    function automatic logic [ADDR_W-1:0] unit_step(unit_e u);
        case (u)
            UNIT_B:  return ADDR_W'(1);
            UNIT_H:  return ADDR_W'(2);
            default: return ADDR_W'(4);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] unit_trim(unit_e u, logic [DATA_W-1:0] d);
        case (u)
            UNIT_B:  return {{(DATA_W-8){1'b0}}, d[7:0]};
            UNIT_H:  return {{(DATA_W-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dmx_addr_gen.sv
module dmx_addr_gen
    import dmx_pkg::*;
#(
    parameter int RELOAD_PERIOD = 4,
    localparam int RC_W = (RELOAD_PERIOD > 1) ? $clog2(RELOAD_PERIOD) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  job_cfg_t          cfg,
    input  logic              step_en,
    input  unit_e             unit,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic              indirect,
    input  logic              reload,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    logic [ADDR_W-1:0] src_base;
    logic [RC_W-1:0]   rcnt;
    logic [ADDR_W-1:0] s_step;
    logic [ADDR_W-1:0] d_step;
    logic              wrap;

    always_comb begin
        s_step = '0;
        if (src_inc)
            s_step = indirect ? ADDR_W'(PTR_STEP) : unit_step(unit);
        d_step = dst_inc ? unit_step(unit) : '0;
        wrap   = reload && (rcnt == RC_W'(RELOAD_PERIOD - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base <= '0;
            src_addr <= '0;
            dst_addr <= '0;
            rcnt     <= '0;
        end else if (load) begin
            src_base <= cfg.src;
            src_addr <= cfg.src;
            dst_addr <= cfg.dst;
            rcnt     <= '0;
        end else if (step_en) begin
            dst_addr <= dst_addr + d_step;
            if (wrap) begin
                src_addr <= src_base;
                rcnt     <= '0;
            end else begin
                src_addr <= src_addr + s_step;
                rcnt     <= rcnt + RC_W'(1);
            end
        end
    end

endmodule

// File: rtl/dmx_counter.sv
module dmx_counter
    import dmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (dec)
            remaining <= remaining - CNT_W'(1);
    end

    assign last = (remaining == CNT_W'(1));

endmodule

// File: rtl/dmx_sequencer.sv
module dmx_sequencer
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              indirect,
    input  unit_e             unit,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              idle,
    output logic              xfer_done
);

    phase_e            phase;
    logic [15:0]       ptr_lo;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            ptr_lo <= '0;
            ptr    <= '0;
            hold   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (go) phase <= indirect ? PH_PLO : PH_RD;
                PH_PLO: if (bus_ready) begin
                    ptr_lo <= bus_rdata[15:0];
                    phase  <= PH_PHI;
                end
                PH_PHI: if (bus_ready) begin
                    ptr   <= {bus_rdata[15:0], ptr_lo};
                    phase <= PH_RD;
                end
                PH_RD: if (bus_ready) begin
                    hold  <= unit_trim(unit, bus_rdata);
                    phase <= PH_WR;
                end
                PH_WR: if (bus_ready) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (phase != PH_IDLE);
        bus_we    = (phase == PH_WR);
        bus_wdata = hold;
        bus_size  = unit;
        bus_addr  = src_addr;
        case (phase)
            PH_PLO: begin
                bus_addr = src_addr;
                bus_size = UNIT_H;
            end
            PH_PHI: begin
                bus_addr = src_addr + ADDR_W'(2);
                bus_size = UNIT_H;
            end
            PH_RD:   bus_addr = indirect ? ptr : src_addr;
            PH_WR:   bus_addr = dst_addr;
            default: bus_addr = src_addr;
        endcase
    end

    assign idle      = (phase == PH_IDLE);
    assign xfer_done = (phase == PH_WR) && bus_ready;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dmx_pkg::*;
#(
    parameter int RELOAD_PERIOD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_unit,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic              cfg_indirect,
    input  logic              cfg_reload,
    input  logic              cfg_auto,
    input  logic              cfg_irq_en,
    input  logic              periph_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              act,
    output logic              done,
    output logic              irq
);

    job_cfg_t          new_cfg;
    job_cfg_t          job;
    logic              accept;
    logic              go;
    logic              idle;
    logic              xfer_done;
    logic              last;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;

    always_comb begin
        new_cfg.src      = cfg_src;
        new_cfg.dst      = cfg_dst;
        new_cfg.count    = cfg_count;
        new_cfg.unit     = unit_e'(cfg_unit);
        new_cfg.src_inc  = cfg_src_inc;
        new_cfg.dst_inc  = cfg_dst_inc;
        new_cfg.indirect = cfg_indirect;
        new_cfg.reload   = cfg_reload;
        new_cfg.auto_req = cfg_auto;
        new_cfg.irq_en   = cfg_irq_en;
    end

    assign accept = cfg_load && !act;
    assign go     = act && idle && (job.auto_req || periph_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            job  <= '0;
            act  <= 1'b0;
            done <= 1'b0;
        end else if (accept) begin
            job  <= new_cfg;
            act  <= 1'b1;
            done <= 1'b0;
        end else if (xfer_done && last) begin
            act  <= 1'b0;
            done <= 1'b1;
        end
    end

    assign irq = done && job.irq_en;

    dmx_addr_gen #(.RELOAD_PERIOD(RELOAD_PERIOD)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .cfg      (new_cfg),
        .step_en  (xfer_done),
        .unit     (job.unit),
        .src_inc  (job.src_inc),
        .dst_inc  (job.dst_inc),
        .indirect (job.indirect),
        .reload   (job.reload),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    dmx_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (cfg_count),
        .dec      (xfer_done),
        .last     (last)
    );

    dmx_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .indirect  (job.indirect),
        .unit      (job.unit),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .idle      (idle),
        .xfer_done (xfer_done)
    );

endmodule

// File: rtl/dmx_checker.sv
module dmx_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_load,
    input logic [31:0] cfg_src,
    input logic [31:0] cfg_dst,
    input logic [23:0] cfg_count,
    input logic [1:0]  cfg_unit,
    input logic        cfg_src_inc,
    input logic        cfg_dst_inc,
    input logic        cfg_indirect,
    input logic        cfg_reload,
    input logic        cfg_auto,
    input logic        cfg_irq_en,
    input logic        periph_req,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_ready,
    input logic        act,
    input logic        done,
    input logic        irq
);

    a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                     && $stable(bus_size) && $stable(bus_wdata)));

    a_r9_quiet_when_inactive: assert property (@(posedge clk) disable iff (rst)
        !act |-> !bus_req);

    a_r7_gap_after_write: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_ready) |=> !bus_req);

    a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

    a_r8_done_ends_job: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !act);

    a_r2_size_legal: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_size != 2'd3));

endmodule

bind dma_xfer_engine dmx_checker i_dmx_checker (.*);

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_src = '0;
    logic [31:0] cfg_dst = '0;
    logic [23:0] cfg_count = '0;
    logic [1:0]  cfg_unit = '0;
    logic        cfg_src_inc = 1'b0;
    logic        cfg_dst_inc = 1'b0;
    logic        cfg_indirect = 1'b0;
    logic        cfg_reload = 1'b0;
    logic        cfg_auto = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        periph_req = 1'b0;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic        act;
    logic        done;
    logic        irq;

    always #2.5 clk = ~clk;

    dma_xfer_engine i_dma_xfer_engine (.*);

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  mem  [0:1023];
    logic [7:0]  mref [0:1023];
    logic [31:0] log_addr [0:63];
    logic        log_we   [0:63];
    int          log_n = 0;
    int          wait_cycles = 0;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [7:0]  cnt;
        logic [1:0]  unit;
        logic        si;
        logic        di;
        logic        ind;
        logic        rel;
        logic [3:0]  wt;
        logic [7:0]  acc;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{32'h000, 32'h200, 8'd5, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 8'd10},
        '{32'h010, 32'h240, 8'd4, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 8'd8},
        '{32'h020, 32'h260, 8'd6, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 8'd12},
        '{32'h300, 32'h280, 8'd3, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'd12},
        '{32'h300, 32'h2A0, 8'd5, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1, 8'd20},
        '{32'h030, 32'h2C0, 8'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 8'd6}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] a, input logic [31:0] e);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, a, e);
        end
    endtask

    function automatic logic [31:0] mget(logic [31:0] a, int nb);
        logic [31:0] v = '0;
        for (int b = 0; b < nb; b++) v |= 32'(mref[(a + b) & 32'h3FF]) << (8 * b);
        return v;
    endfunction

    // Bus responder: reply after wait_cycles stall cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ready) begin
                bus_ready = 1'b0;
            end else if (bus_req) begin
                if (wait_cycles > 0) begin
                    wait_cycles--;
                end else begin
                    int nb;
                    nb = 1 << bus_size;
                    if (log_n < 64) begin
                        log_addr[log_n] = bus_addr;
                        log_we[log_n]   = bus_we;
                    end
                    log_n++;
                    if (bus_we) begin
                        for (int b = 0; b < nb; b++)
                            mem[(bus_addr + b) & 32'h3FF] = bus_wdata[8*b +: 8];
                    end else begin
                        bus_rdata = '0;
                        for (int b = 0; b < nb; b++)
                            bus_rdata[8*b +: 8] = mem[(bus_addr + b) & 32'h3FF];
                    end
                    bus_ready = 1'b1;
                    wait_cycles = wait_reload;
                end
            end
        end
    end

    int wait_reload = 0;

    task automatic model_run(input logic [31:0] src, input logic [31:0] dst,
                             input int cnt, input int unit, input bit si, input bit di,
                             input bit ind, input bit rel);
        logic [31:0] s, d, a;
        int nb;
        for (int i = 0; i < 1024; i++) mref[i] = mem[i];
        s = src;
        d = dst;
        nb = 1 << unit;
        for (int i = 0; i < cnt; i++) begin
            a = ind ? (mget(s, 2) | (mget(s + 2, 2) << 16)) : s;
            for (int b = 0; b < nb; b++) mref[(d + b) & 32'h3FF] = mref[(a + b) & 32'h3FF];
            if (rel && (i % 4 == 3)) s = src;
            else if (si) s = s + (ind ? 4 : nb);
            if (di) d = d + nb;
        end
    endtask

    task automatic load_job(input logic [31:0] src, input logic [31:0] dst,
                            input int cnt, input int unit, input bit si, input bit di,
                            input bit ind, input bit rel, input bit au, input bit ie);
        @(negedge clk);
        cfg_src = src; cfg_dst = dst; cfg_count = 24'(cnt); cfg_unit = 2'(unit);
        cfg_src_inc = si; cfg_dst_inc = di; cfg_indirect = ind; cfg_reload = rel;
        cfg_auto = au; cfg_irq_en = ie; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(done, req, "job completion", 32'(done), 32'd1);
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 1024; i++)
            if (mem[i] !== mref[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, "memory image mismatches", 32'(bad), 32'd0);
        if (first >= 0)
            chk(1'b0, req, "first bad byte", 32'(mem[first]), 32'(mref[first]));
    endtask

    initial begin
        int seen;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] p;
            p = 32'h040 + 32'(k) * 32'h10;
            for (int b = 0; b < 4; b++) mem[32'h300 + 4*k + b] = p[8*b +: 8];
        end

        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        chk(!bus_req && !act && !done && !irq, "R1", "outputs in reset",
            {bus_req, act, done, irq}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_req && !act && !done && !irq, "R1", "outputs after reset",
            {bus_req, act, done, irq}, 32'd0);

        // Vector table: auto-request jobs with reference-model comparison
        for (int v = 0; v < 6; v++) begin
            model_run(VEC[v].src, VEC[v].dst, VEC[v].cnt, VEC[v].unit,
                      VEC[v].si, VEC[v].di, VEC[v].ind, VEC[v].rel);
            wait_reload = VEC[v].wt;
            wait_cycles = VEC[v].wt;
            log_n = 0;
            load_job(VEC[v].src, VEC[v].dst, VEC[v].cnt, VEC[v].unit,
                     VEC[v].si, VEC[v].di, VEC[v].ind, VEC[v].rel, 1'b1, 1'b0);
            chk(act && !done, "R10", "act after load", {act, done}, 32'd2);
            wait_done("R8");
            chk(!act && !irq, "R8", "act/irq at end, irq disabled", {act, irq}, 32'd0);
            chk(log_n == VEC[v].acc, "R2 R5", "bus access count", 32'(log_n), 32'(VEC[v].acc));
            cmp_mem("R2 R4 R5 R6");
            if (VEC[v].ind) begin
                chk(log_addr[0] == VEC[v].src, "R5", "pointer low read", log_addr[0], VEC[v].src);
                chk(log_addr[1] == VEC[v].src + 2, "R5", "pointer high read",
                    log_addr[1], VEC[v].src + 2);
                chk(log_addr[2] == 32'h040, "R5", "data read at fetched address",
                    log_addr[2], 32'h040);
                chk(log_we[3] && !log_we[2], "R5", "write last", {log_we[2], log_we[3]}, 32'd1);
            end
            if (v == 2)
                chk(log_addr[8] == VEC[v].src, "R6", "fifth read reloaded", log_addr[8], VEC[v].src);
        end

        // R7/R9: peripheral-gated job
        wait_reload = 0;
        wait_cycles = 0;
        model_run(32'h050, 32'h2E0, 3, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        log_n = 0;
        periph_req = 1'b0;
        load_job(32'h050, 32'h2E0, 3, 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (30) @(negedge clk);
        chk(log_n == 0 && act, "R7", "no transfer without periph_req", 32'(log_n), 32'd0);
        periph_req = 1'b1;
        wait_done("R7");
        chk(irq, "R8", "irq with enable", 32'(irq), 32'd1);
        repeat (20) @(negedge clk);
        chk(log_n == 6, "R9", "requests after done ignored", 32'(log_n), 32'd6);
        chk(!bus_req, "R9", "bus idle after done", 32'(bus_req), 32'd0);
        cmp_mem("R7");
        periph_req = 1'b0;

        // R10: load while active is ignored
        for (int i = 0; i < 4; i++) mem[32'h380 + i] = 8'hA5;
        model_run(32'h060, 32'h3A0, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        wait_reload = 1;
        wait_cycles = 1;
        log_n = 0;
        load_job(32'h060, 32'h3A0, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(!done, "R10", "done cleared by load", 32'(done), 32'd0);
        repeat (4) @(negedge clk);
        load_job(32'h070, 32'h380, 2, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        wait_done("R10");
        chk(log_n == 16, "R10", "original job length kept", 32'(log_n), 32'd16);
        chk(!irq, "R10", "irq enable of ignored load not taken", 32'(irq), 32'd0);
        seen = 0;
        for (int i = 0; i < 4; i++) if (mem[32'h380 + i] != 8'hA5) seen++;
        chk(seen == 0, "R10", "ignored destination untouched", 32'(seen), 32'd0);
        cmp_mem("R10");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule